// File: doc/BRIEF.md
# GPIO Port with Atomic Set/Clear/Toggle

This block is a 32-pin general-purpose I/O data port that sits on a simple memory-mapped request/acknowledge bus. Software keeps an output latch and a per-pin direction word in it. Three write-only strobe registers set, clear or invert chosen latch bits in one bus write. Because of this, two agents can change different pins without a read-modify-write sequence that could race. The latch drives the pin value outputs, and the direction word drives the per-pin output enables. Pin levels come back through a two-stage synchronizer into a read-only input word.

A small two-state bus controller handles each transfer. In `BUS_IDLE` it accepts a request and takes the transition *accept* to `BUS_RESP`. In the same edge it performs any write and captures the read word. In `BUS_RESP` it raises the acknowledge for one cycle and takes the transition *complete* back to `BUS_IDLE`. A request is only sampled in `BUS_IDLE`.

Top module: `gpio_atomic_port`

## Requirements
- R1: After reset the output latch and direction word are all zeros: `pin_out` and `pin_oe` are zero, `ack` is low.
- R2: The data word at offset 0x00 is read-write. Its read returns the latch value and not the pin level, and `pin_out` equals the latch.
- R3: A write to offset 0x04 sets each latch bit whose write bit is 1 and leaves the rest unchanged.
- R4: A write to offset 0x08 clears each latch bit whose write bit is 1 and leaves the rest unchanged.
- R5: A write to offset 0x0C inverts each latch bit whose write bit is 1 and leaves the rest unchanged.
- R6: The direction word at offset 0x14 is read-write. Bit value 1 means output and 0 means input, and `pin_oe` equals the direction word.
- R7: A read of offset 0x10 returns the pin levels through a two-flop synchronizer. A read accepted one or two edges after a pin change still returns the old level. A read accepted at the third edge returns the new level.
- R8: Reads of offsets 0x04, 0x08, 0x0C, of any unmapped offset, and of any offset with low bits not 00 return zero. Writes to 0x10 and to unmapped offsets change nothing.
- R9: A request seen in `BUS_IDLE` is accepted at that edge. `ack` is high for exactly the next cycle, with `rdata` valid in that cycle. A request held while `ack` is high is not accepted a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Bus request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte offset |
| wdata | input | 32 | Write data |
| ack | output | 1 | One-cycle transfer acknowledge |
| rdata | output | 32 | Read data, valid while ack is high |
| pin_in | input | 32 | Pin levels |
| pin_out | output | 32 | Pin drive values (latch) |
| pin_oe | output | 32 | Per-pin output enable (direction) |

## Verification
A latch or direction bit that is wrong shows up at `pin_out` or `pin_oe` on the cycle after the write edge. The bench compares both outputs against a model after every strobe write, so a corrupted bit is caught within one transfer. A bad read-mux or decode entry shows up only in `rdata` while `ack` is high, so every offset is read back, including the write-only and unmapped ones. A synchronizer that is too short or too long shifts input visibility by one edge. Directed reads at one, two and three edges after a pin change pin this down.

// File: rtl/gpio_atomic_pkg.sv
package gpio_atomic_pkg;
    localparam logic [7:0] OFS_DATA = 8'h00;
    localparam logic [7:0] OFS_SET  = 8'h04;
    localparam logic [7:0] OFS_CLR  = 8'h08;
    localparam logic [7:0] OFS_TGL  = 8'h0C;
    localparam logic [7:0] OFS_IN   = 8'h10;
    localparam logic [7:0] OFS_DIR  = 8'h14;

    typedef enum logic [2:0] {
        SEL_DATA,
        SEL_SET,
        SEL_CLR,
        SEL_TGL,
        SEL_IN,
        SEL_DIR,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d_in[i];
                s2 <= s1;
            end
        end
        assign q_out[i] = s2;
    end
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
    import gpio_atomic_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q
);
    logic [WIDTH-1:0] latch_nxt;

    always_comb begin
        latch_nxt = latch_q;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_DATA: latch_nxt = wdata;
                SEL_SET:  latch_nxt = latch_q | wdata;
                SEL_CLR:  latch_nxt = latch_q & ~wdata;
                SEL_TGL:  latch_nxt = latch_q ^ wdata;
                default:  latch_nxt = latch_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else begin
            latch_q <= latch_nxt;
            if (wr_en && wr_sel == SEL_DIR) dir_q <= wdata;
        end
    end

    // R3
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_SET) |=>
            (((latch_q & $past(wdata)) == $past(wdata)) &&
             ((latch_q & ~$past(wdata)) == ($past(latch_q) & ~$past(wdata)))));
    // R4
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CLR) |=>
            (((latch_q & $past(wdata)) == '0) &&
             ((latch_q & ~$past(wdata)) == ($past(latch_q) & ~$past(wdata)))));
    // R5
    tgl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_TGL) |=> ((latch_q ^ $past(latch_q)) == $past(wdata)));
    // R8
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == SEL_DIR) |=> $stable(dir_q));
    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == SEL_IN || wr_sel == SEL_NONE || wr_sel == SEL_DIR)) |=> $stable(latch_q));
endmodule

// File: rtl/gpio_bus_ctrl.sv
module gpio_bus_ctrl
    import gpio_atomic_pkg::*;
#(
    parameter int AW    = 8,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] in_q,
    output logic             wr_en,
    output reg_sel_e         sel,
    output logic             ack,
    output logic [WIDTH-1:0] rdata
);
    localparam int DW = (AW < 8) ? AW : 8;

    bus_state_e       state, state_nxt;
    logic             accept;
    logic [WIDTH-1:0] rd_mux;
    logic [7:0]       ofs;

    always_comb begin
        ofs = '0;
        ofs[DW-1:0] = addr[DW-1:0];
    end

    always_comb begin
        sel = SEL_NONE;
        if (AW <= 8 || addr[AW-1:DW] == '0) begin
            unique case (ofs)
                OFS_DATA: sel = SEL_DATA;
                OFS_SET:  sel = SEL_SET;
                OFS_CLR:  sel = SEL_CLR;
                OFS_TGL:  sel = SEL_TGL;
                OFS_IN:   sel = SEL_IN;
                OFS_DIR:  sel = SEL_DIR;
                default:  sel = SEL_NONE;
            endcase
        end
    end

    assign accept = (state == BUS_IDLE) && req;
    assign wr_en  = accept && we;

    always_comb begin
        unique case (sel)
            SEL_DATA: rd_mux = latch_q;
            SEL_IN:   rd_mux = in_q;
            SEL_DIR:  rd_mux = dir_q;
            default:  rd_mux = '0;
        endcase
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            BUS_IDLE: if (req) state_nxt = BUS_RESP;
            BUS_RESP: state_nxt = BUS_IDLE;
            default:  state_nxt = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= BUS_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            rdata <= '0;
        end else begin
            ack <= accept;
            if (accept) rdata <= we ? '0 : rd_mux;
        end
    end

    // R9
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(req));
    // R9
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R8
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !we && (sel == SEL_SET || sel == SEL_CLR || sel == SEL_TGL || sel == SEL_NONE))
            |=> (rdata == '0));
endmodule

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port
    import gpio_atomic_pkg::*;
#(
    parameter int AW    = 8,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic             ack,
    output logic [WIDTH-1:0] rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    logic [WIDTH-1:0] latch_q, dir_q, in_q;
    logic             wr_en;
    reg_sel_e         sel;

    gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(pin_in), .q_out(in_q)
    );

    gpio_out_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(sel),
        .wdata(wdata), .latch_q(latch_q), .dir_q(dir_q)
    );

    gpio_bus_ctrl #(.AW(AW), .WIDTH(WIDTH)) u_bus (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .latch_q(latch_q), .dir_q(dir_q), .in_q(in_q),
        .wr_en(wr_en), .sel(sel), .ack(ack), .rdata(rdata)
    );

    assign pin_out = latch_q;
    assign pin_oe  = dir_q;
endmodule

// File: tb/gpio_atomic_port_bench.sv
module gpio_atomic_port_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        ack;
    logic [31:0] rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int checks = 0;
    int failures = 0;
    logic [31:0] m_lat = '0;
    logic [31:0] m_dir = '0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_atomic_port u_gpio_atomic_port (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .ack(ack), .rdata(rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [31:0] model_next(input logic [7:0] a, input logic [31:0] d,
                                               input logic [31:0] cur);
        case (a)
            8'h00:   return d;
            8'h04:   return cur | d;
            8'h08:   return cur & ~d;
            8'h0C:   return cur ^ d;
            default: return cur;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_lat;
            8'h14:   return m_dir;
            8'h10:   return pin_in;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        chk("R9 ack", {31'b0, ack}, 32'h1);
        rd = rdata;
        @(posedge clk); @(negedge clk);
        chk("R9 single ack", {31'b0, ack}, 32'h0);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        xfer(1'b1, a, d, dummy);
        m_lat = model_next(a, d, m_lat);
        if (a == 8'h14) m_dir = d;
        chk("R2 pin_out", pin_out, m_lat);
        chk("R6 pin_oe", pin_oe, m_dir);
    endtask

    task automatic rd_chk(input string r, input logic [7:0] a);
        logic [31:0] v;
        logic [31:0] e;
        e = model_read(a);
        xfer(1'b0, a, 32'h0, v);
        chk(r, v, e);
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pin_out", pin_out, 32'h0);
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 ack", {31'b0, ack}, 32'h0);
        rd_chk("R1 data reads zero", 8'h00);
        rd_chk("R1 dir reads zero", 8'h14);

        // R2 data word, returns latch not pins
        pin_in = 32'h0F0F_0F0F;
        wr(8'h00, 32'hA5A5_1234);
        rd_chk("R2 data readback", 8'h00);
        // R3 / R4 / R5 directed
        wr(8'h04, 32'hFFFF_0000);
        chk("R3 set", pin_out, 32'hFFFF_1234);
        wr(8'h08, 32'h00F0_00F0);
        chk("R4 clear", pin_out, 32'hFF0F_1204);
        wr(8'h0C, 32'h8000_0001);
        chk("R5 toggle", pin_out, 32'h7F0F_1205);
        // R6 direction
        wr(8'h14, 32'hDEAD_BEEF);
        chk("R6 oe", pin_oe, 32'hDEAD_BEEF);
        rd_chk("R6 dir readback", 8'h14);

        // R8 write-only reads, ignored writes, unmapped
        rd_chk("R8 set reads zero", 8'h04);
        rd_chk("R8 clr reads zero", 8'h08);
        rd_chk("R8 tgl reads zero", 8'h0C);
        rd_chk("R8 unmapped reads zero", 8'h40);
        rd_chk("R8 misaligned reads zero", 8'h01);
        wr(8'h10, 32'h1234_5678);
        wr(8'h44, 32'hFFFF_FFFF);
        wr(8'h05, 32'hFFFF_FFFF);
        chk("R8 ignored write latch", pin_out, 32'h7F0F_1205);
        chk("R8 ignored write dir", pin_oe, 32'hDEAD_BEEF);
        @(negedge clk);
        rd_chk("R8 input unaffected", 8'h10);

        // R7 synchronizer latency
        pin_in = 32'h1111_2222;
        repeat (3) @(negedge clk);
        pin_in = 32'h3333_4444;
        xfer(1'b0, 8'h10, 32'h0, v);
        chk("R7 one edge old", v, 32'h1111_2222);
        pin_in = 32'h5555_6666;
        @(negedge clk);
        xfer(1'b0, 8'h10, 32'h0, v);
        chk("R7 two edges old", v, 32'h3333_4444);
        pin_in = 32'h7777_8888;
        @(negedge clk); @(negedge clk);
        xfer(1'b0, 8'h10, 32'h0, v);
        chk("R7 third edge new", v, 32'h7777_8888);

        // R9 request held across ack is not re-accepted
        req = 1'b1; we = 1'b1; addr = 8'h0C; wdata = 32'h0000_00FF;
        @(posedge clk); @(negedge clk);
        chk("R9 held ack", {31'b0, ack}, 32'h1);
        @(posedge clk); @(negedge clk);
        chk("R9 held no ack", {31'b0, ack}, 32'h0);
        req = 1'b0; we = 1'b0;
        m_lat = m_lat ^ 32'h0000_00FF;
        @(negedge clk);
        chk("R9 single toggle", pin_out, m_lat);

        // random mix R2..R8
        for (int i = 0; i < 400; i++) begin
            logic [2:0] k;
            logic [7:0] a;
            k = 3'($urandom_range(0, 7));
            case (k)
                3'd0: a = 8'h00;
                3'd1: a = 8'h04;
                3'd2: a = 8'h08;
                3'd3: a = 8'h0C;
                3'd4: a = 8'h10;
                3'd5: a = 8'h14;
                default: a = 8'(($urandom_range(0, 63)) << 2);
            endcase
            if ($urandom_range(0, 2) != 0) begin
                wr(a, $urandom());
            end else begin
                if (a == 8'h10) begin
                    pin_in = $urandom();
                    @(negedge clk); @(negedge clk);
                end
                rd_chk("R2-R8 random read", a);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule